// File: doc/BRIEF.md
# Multi-Channel Copy Engine Register Decoder

This block is the register front end of a multi-channel memory copy engine. A host reaches it through a simple request/response port. Each request carries a byte offset, a direction, an access size of 1, 2, 4 or 8 bytes and, for writes, the data. The offset space is split into 128-byte windows. Window 0 holds the global registers, and window k+1 holds the registers of channel k. The block checks the access size against the addressed register and applies that register's side effects: clear on read, set on read, write-one-to-clear, ignored writes, and split low/high updates of 64-bit pointers. A command write sends a one-cycle strobe to the selected channel.

The block is controlled by a two-state machine. In S_IDLE, `req_ready` is high. A request accepted in S_IDLE (transition ACCEPT) applies its side effects at that clock edge, captures the response, and moves the block to S_RESP. S_RESP keeps `rsp_valid` high until `rsp_ready` is seen (transition RELEASE), and the block then returns to S_IDLE. Asynchronous status inputs set bits in the attention and per-channel error registers. When a set and a clear hit the same bit in the same cycle, the set wins.

Top module: `copy_regfile`

## Requirements
- R1: Offset bits [6:0] select a register inside a window, and bits above them select the window. Window 0 is global, and window k+1 is channel k. A window above NCHAN gives `rsp_err`=1 and has no effect.
- R2: An unknown offset, or a size other than the one the register allows, gives `rsp_err`=1 and `rsp_rdata`=0, and changes no state and raises no strobe. Sizes are encoded in `req_size` as 0=1B, 1=2B, 2=4B, 3=8B.
- R3: Global offset 0x00 (1B) reads NCHAN. Global offset 0x01 (1B) reads the bit index of the most significant set bit of MAX_XFER. Writes to these two registers, to attention status and to channel status are accepted with `rsp_err`=0 and change nothing.
- R4: Attention status is at global offset 0x04 (4B). A read returns the value and then clears it. `attn_set` bits are ORed in every cycle and win over a clear in the same cycle.
- R5: Interrupt control is at global offset 0x02 (1B), with master enable in bit 0. A read returns it and then clears master enable. A write loads bit 0 from `req_wdata[0]`.
- R6: Channel control is at channel offset 0x00 (2B) and resets to 0x0001. Bit 0 is interrupt-disable and bit 8 is in-use. A read returns the value and then sets bit 8. A write stores all bits except bit 0; for bit 0, a 1 clears it and a 0 keeps the old value.
- R7: The chain pointer is at channel offset 0x08 (high half at 0x0C), and the completion pointer is at 0x10 (high half at 0x14). Both are 64-bit. An 8B access at the base offset reads or writes the whole value. A 4B access at the base offset reads or writes the low half, and a 4B access at the high offset reads or writes the upper half. A 4B write keeps the other half.
- R8: Channel error is at channel offset 0x04 (4B). A write applies new = old AND NOT data. `err_set_bits` is ORed into channel `err_set_chan` when `err_set_valid` is high, and wins over a clear in the same cycle.
- R9: A 1B write to channel offset 0x02 (command) raises `cmd_strobe[k]` for exactly one cycle, in the first response cycle, with `cmd_data` equal to the written byte. A read of the command register returns 0.
- R10: `req_ready` is high only in S_IDLE. An accepted request gets exactly one response, which appears in the next cycle and is held stable until `rsp_ready` is high.
- R11: Channel status is at channel offset 0x18 (8B). It reads bit 0 = NOT `chan_busy[k]`, and all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset |
| req_size | input | 2 | Access size code |
| req_wdata | input | 64 | Write data, right-justified |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response taken |
| rsp_rdata | output | 64 | Read data, right-justified; 0 for writes |
| rsp_err | output | 1 | Illegal access |
| cmd_strobe | output | NCHAN | One-cycle command pulse per channel |
| cmd_data | output | 8 | Last command byte written |
| attn_set | input | 32 | Attention bits to set |
| err_set_valid | input | 1 | Error set request |
| err_set_chan | input | CH_W | Channel for error set |
| err_set_bits | input | 32 | Error bits to set |
| chan_busy | input | NCHAN | Per-channel busy flags |

## Verification
Two functions can meet in one cycle. The first is a clear-on-read of attention status while `attn_set` raises bits. The second is a write-one-to-clear of a channel error register while `err_set_valid` targets the same channel. The bench provokes both with directed cases that drive the set and the clearing access in the same cycle. It also has random traffic that pulses the set inputs during about a quarter of the accesses. Each result is judged against a bench model that applies the clear first and then ORs in the set. The model is checked both through the returned read data and through a later read of the same register.

// File: rtl/creg_pkg.sv
package creg_pkg;

    typedef enum logic [1:0] {
        SZ_1 = 2'd0,
        SZ_2 = 2'd1,
        SZ_4 = 2'd2,
        SZ_8 = 2'd3
    } size_e;

    typedef enum logic [3:0] {
        RID_NONE, RID_CHANCNT, RID_XFERCAP, RID_INTCTRL, RID_ATTN,
        RID_CTRL, RID_CMD, RID_ERR, RID_CHAIN, RID_CHAIN_HI,
        RID_CMPL, RID_CMPL_HI, RID_STATUS
    } rid_e;

    localparam int WIN_BITS = 7;

    // global window offsets
    localparam logic [6:0] GO_CHANCNT = 7'h00;
    localparam logic [6:0] GO_XFERCAP = 7'h01;
    localparam logic [6:0] GO_INTCTRL = 7'h02;
    localparam logic [6:0] GO_ATTN    = 7'h04;

    // channel window offsets
    localparam logic [6:0] CO_CTRL    = 7'h00;
    localparam logic [6:0] CO_CMD     = 7'h02;
    localparam logic [6:0] CO_ERR     = 7'h04;
    localparam logic [6:0] CO_CHAIN   = 7'h08;
    localparam logic [6:0] CO_CHAINHI = 7'h0C;
    localparam logic [6:0] CO_CMPL    = 7'h10;
    localparam logic [6:0] CO_CMPLHI  = 7'h14;
    localparam logic [6:0] CO_STATUS  = 7'h18;

    localparam int CTRL_INTDIS_BIT = 0;
    localparam int CTRL_INUSE_BIT  = 8;
    localparam logic [15:0] CTRL_RESET = 16'h0001;

    function automatic logic size_ok(rid_e r, size_e s);
        unique case (r)
            RID_CHANCNT, RID_XFERCAP, RID_INTCTRL, RID_CMD: return s == SZ_1;
            RID_CTRL:                                        return s == SZ_2;
            RID_ATTN, RID_ERR, RID_CHAIN_HI, RID_CMPL_HI:    return s == SZ_4;
            RID_STATUS:                                      return s == SZ_8;
            RID_CHAIN, RID_CMPL:                             return (s == SZ_4) || (s == SZ_8);
            default:                                         return 1'b0;
        endcase
    endfunction

    // 64-bit pointer update: whole, low half or high half
    function automatic logic [63:0] ptr_update(logic [63:0] old, logic [63:0] wd,
                                               logic hi, logic full);
        if (full)    return wd;
        else if (hi) return {wd[31:0], old[31:0]};
        else         return {old[63:32], wd[31:0]};
    endfunction

endpackage

// File: rtl/creg_decode.sv
module creg_decode
    import creg_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NCHAN  = 4,
    parameter int CH_W   = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  size_e             size,
    output rid_e              rid,
    output logic [CH_W-1:0]   chan,
    output logic              bad
);
    localparam int WIN_W = ADDR_W - WIN_BITS;
    localparam logic [WIN_W-1:0] NCHAN_W = WIN_W'(NCHAN);

    logic [WIN_W-1:0] window;
    logic [WIN_W-1:0] win_m1;
    logic [6:0]       offset;
    logic             is_global;
    logic             chan_in_range;

    assign window        = addr[ADDR_W-1:WIN_BITS];
    assign offset        = addr[WIN_BITS-1:0];
    assign is_global     = (window == '0);
    assign chan_in_range = !is_global && (window <= NCHAN_W);
    assign win_m1        = window - WIN_W'(1);
    assign chan          = win_m1[CH_W-1:0];

    always_comb begin
        rid = RID_NONE;
        if (is_global) begin
            case (offset)
                GO_CHANCNT: rid = RID_CHANCNT;
                GO_XFERCAP: rid = RID_XFERCAP;
                GO_INTCTRL: rid = RID_INTCTRL;
                GO_ATTN:    rid = RID_ATTN;
                default:    rid = RID_NONE;
            endcase
        end else if (chan_in_range) begin
            case (offset)
                CO_CTRL:    rid = RID_CTRL;
                CO_CMD:     rid = RID_CMD;
                CO_ERR:     rid = RID_ERR;
                CO_CHAIN:   rid = RID_CHAIN;
                CO_CHAINHI: rid = RID_CHAIN_HI;
                CO_CMPL:    rid = RID_CMPL;
                CO_CMPLHI:  rid = RID_CMPL_HI;
                CO_STATUS:  rid = RID_STATUS;
                default:    rid = RID_NONE;
            endcase
        end
    end

    assign bad = (rid == RID_NONE) || !size_ok(rid, size);

endmodule

// File: rtl/creg_chan.sv
module creg_chan
    import creg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hit,
    input  logic        wr,
    input  rid_e        rid,
    input  size_e       size,
    input  logic [63:0] wdata,
    input  logic        eset,
    input  logic [31:0] ebits,
    output logic [15:0] ctrl_q,
    output logic [63:0] chain_q,
    output logic [63:0] cmpl_q,
    output logic [31:0] err_q
);
    logic        err_clr;
    logic [31:0] err_kept;

    assign err_clr  = hit && wr && (rid == RID_ERR);
    assign err_kept = err_clr ? (err_q & ~wdata[31:0]) : err_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= CTRL_RESET;
            chain_q <= '0;
            cmpl_q  <= '0;
            err_q   <= '0;
        end else begin
            err_q <= err_kept | (eset ? ebits : 32'd0);
            if (hit) begin
                case (rid)
                    RID_CTRL: begin
                        if (wr)
                            ctrl_q <= {wdata[15:1],
                                       wdata[CTRL_INTDIS_BIT] ? 1'b0 : ctrl_q[CTRL_INTDIS_BIT]};
                        else
                            ctrl_q[CTRL_INUSE_BIT] <= 1'b1;
                    end
                    RID_CHAIN:    if (wr) chain_q <= ptr_update(chain_q, wdata, 1'b0, size == SZ_8);
                    RID_CHAIN_HI: if (wr) chain_q <= ptr_update(chain_q, wdata, 1'b1, 1'b0);
                    RID_CMPL:     if (wr) cmpl_q  <= ptr_update(cmpl_q, wdata, 1'b0, size == SZ_8);
                    RID_CMPL_HI:  if (wr) cmpl_q  <= ptr_update(cmpl_q, wdata, 1'b1, 1'b0);
                    default: ;
                endcase
            end
        end
    end

    AST_INUSE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr && rid == RID_CTRL) |=> ctrl_q[CTRL_INUSE_BIT]); // R6

    AST_HIGH_WRITE_KEEPS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr && rid == RID_CHAIN_HI) |=> chain_q[31:0] == $past(chain_q[31:0])); // R7

    AST_ERR_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr && rid == RID_ERR && !eset) |=> (err_q & $past(wdata[31:0])) == 32'd0); // R8

endmodule

// File: rtl/copy_regfile.sv
module copy_regfile
    import creg_pkg::*;
#(
    parameter int NCHAN    = 4,
    parameter int MAX_XFER = 4096,
    parameter int ADDR_W   = 16,
    localparam int CH_W    = (NCHAN > 1) ? $clog2(NCHAN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [63:0]       rsp_rdata,
    output logic              rsp_err,
    output logic [NCHAN-1:0]  cmd_strobe,
    output logic [7:0]        cmd_data,
    input  logic [31:0]       attn_set,
    input  logic              err_set_valid,
    input  logic [CH_W-1:0]   err_set_chan,
    input  logic [31:0]       err_set_bits,
    input  logic [NCHAN-1:0]  chan_busy
);
    localparam int XCAP_IDX = $clog2(MAX_XFER + 1) - 1;

    typedef enum logic {S_IDLE, S_RESP} st_e;
    st_e st_q, st_d;

    size_e            sz;
    rid_e             rid;
    logic [CH_W-1:0]  ch;
    logic             bad, accept, acc_ok;
    logic             me_q;
    logic [31:0]      attn_q;
    logic [63:0]      rd_val;

    logic [15:0] ctrl_a  [NCHAN];
    logic [63:0] chain_a [NCHAN];
    logic [63:0] cmpl_a  [NCHAN];
    logic [31:0] err_a   [NCHAN];

    assign sz = size_e'(req_size);

    creg_decode #(.ADDR_W(ADDR_W), .NCHAN(NCHAN), .CH_W(CH_W)) u_decode (
        .addr(req_addr), .size(sz), .rid(rid), .chan(ch), .bad(bad)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state: ACCEPT and RELEASE transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE: if (accept)    st_d = S_RESP;
            S_RESP: if (rsp_ready) st_d = S_IDLE;
        endcase
    end

    assign req_ready = (st_q == S_IDLE);
    assign rsp_valid = (st_q == S_RESP);
    assign accept    = req_valid && req_ready;
    assign acc_ok    = accept && !bad;

    // read data mux
    always_comb begin
        rd_val = '0;
        case (rid)
            RID_CHANCNT:  rd_val = 64'(NCHAN);
            RID_XFERCAP:  rd_val = 64'(XCAP_IDX);
            RID_INTCTRL:  rd_val = {63'd0, me_q};
            RID_ATTN:     rd_val = {32'd0, attn_q};
            RID_CTRL:     rd_val = {48'd0, ctrl_a[ch]};
            RID_ERR:      rd_val = {32'd0, err_a[ch]};
            RID_CHAIN:    rd_val = (sz == SZ_8) ? chain_a[ch] : {32'd0, chain_a[ch][31:0]};
            RID_CHAIN_HI: rd_val = {32'd0, chain_a[ch][63:32]};
            RID_CMPL:     rd_val = (sz == SZ_8) ? cmpl_a[ch] : {32'd0, cmpl_a[ch][31:0]};
            RID_CMPL_HI:  rd_val = {32'd0, cmpl_a[ch][63:32]};
            RID_STATUS:   rd_val = {63'd0, !chan_busy[ch]};
            default:      rd_val = '0;
        endcase
    end

    // response and strobe outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_rdata  <= '0;
            rsp_err    <= 1'b0;
            cmd_strobe <= '0;
            cmd_data   <= '0;
        end else begin
            cmd_strobe <= '0;
            if (accept) begin
                rsp_err   <= bad;
                rsp_rdata <= (bad || req_write) ? 64'd0 : rd_val;
                if (acc_ok && req_write && rid == RID_CMD) begin
                    cmd_strobe <= NCHAN'(1) << ch;
                    cmd_data   <= req_wdata[7:0];
                end
            end
        end
    end

    // global registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            me_q   <= 1'b0;
            attn_q <= '0;
        end else begin
            attn_q <= ((acc_ok && !req_write && rid == RID_ATTN) ? 32'd0 : attn_q) | attn_set;
            if (acc_ok && rid == RID_INTCTRL)
                me_q <= req_write ? req_wdata[0] : 1'b0;
        end
    end

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        creg_chan u_chan (
            .clk(clk), .rst_n(rst_n),
            .hit(acc_ok && ch == CH_W'(c)),
            .wr(req_write), .rid(rid), .size(sz), .wdata(req_wdata),
            .eset(err_set_valid && err_set_chan == CH_W'(c)),
            .ebits(err_set_bits),
            .ctrl_q(ctrl_a[c]), .chain_q(chain_a[c]),
            .cmpl_q(cmpl_a[c]), .err_q(err_a[c])
        );
    end

    AST_BAD_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && bad) |=> (rsp_err && cmd_strobe == '0 && rsp_rdata == 64'd0)); // R2

    AST_ATTN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && !req_write && rid == RID_ATTN && attn_set == 32'd0) |=> attn_q == 32'd0); // R4

    AST_ME_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ok && !req_write && rid == RID_INTCTRL) |=> !me_q); // R5

    AST_CMD_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cmd_strobe)); // R9

    AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe != '0) |=> (cmd_strobe == '0)); // R9

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && $stable(rsp_err))); // R10

    AST_NO_READY_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready); // R10

endmodule

// File: tb/copy_regfile_bench.sv
module copy_regfile_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 4;
    localparam int MAXX = 4096;
    localparam int AW   = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0, rsp_ready = 1;
    logic [AW-1:0] req_addr = '0;
    logic [1:0] req_size = '0;
    logic [63:0] req_wdata = '0;
    logic req_ready, rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic [NCH-1:0] cmd_strobe;
    logic [7:0] cmd_data;
    logic [31:0] attn_set = '0;
    logic err_set_valid = 0;
    logic [1:0] err_set_chan = '0;
    logic [31:0] err_set_bits = '0;
    logic [NCH-1:0] chan_busy = 4'b0101;

    int checks = 0, errors = 0;
    bit done = 0;

    // bench model state
    logic [15:0] m_ctrl [NCH];
    logic [63:0] m_chain[NCH];
    logic [63:0] m_cmpl [NCH];
    logic [31:0] m_err  [NCH];
    logic        m_me;
    logic [31:0] m_attn;

    copy_regfile #(.NCHAN(NCH), .MAX_XFER(MAXX), .ADDR_W(AW)) u_copy_regfile (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_size(req_size),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .cmd_strobe(cmd_strobe),
        .cmd_data(cmd_data), .attn_set(attn_set), .err_set_valid(err_set_valid),
        .err_set_chan(err_set_chan), .err_set_bits(err_set_bits), .chan_busy(chan_busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int msb_index(int v);
        int r = 0;
        for (int i = 0; i < 32; i++) if (v[i]) r = i;
        return r;
    endfunction

    task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(logic [15:0] a);
        if (a[15:7] == 0) begin
            case (a[6:0])
                7'h00, 7'h01: return "R3";
                7'h02: return "R5";
                7'h04: return "R4";
                default: return "R2";
            endcase
        end
        if (a[15:7] > NCH) return "R1";
        case (a[6:0])
            7'h00: return "R6";
            7'h02: return "R9";
            7'h04: return "R8";
            7'h08, 7'h0C, 7'h10, 7'h14: return "R7";
            7'h18: return "R11";
            default: return "R2";
        endcase
    endfunction

    // model of one access; clear first, then OR in sets
    task automatic model(input logic wr, input logic [15:0] a, input logic [1:0] s,
                         input logic [63:0] wd, input logic [31:0] aset,
                         input logic ev, input logic [1:0] ec, input logic [31:0] eb,
                         output logic [63:0] rd, output logic er, output logic [NCH-1:0] stb);
        int w = int'(a[15:7]);
        int c = w - 1;
        logic [6:0] o = a[6:0];
        logic attn_clr = 0;
        rd = '0; er = 1'b1; stb = '0;
        if (w == 0) begin
            case (o)
                7'h00: if (s == 0) begin er = 0; if (!wr) rd = 64'(NCH); end
                7'h01: if (s == 0) begin er = 0; if (!wr) rd = 64'(msb_index(MAXX)); end
                7'h02: if (s == 0) begin er = 0;
                           if (wr) m_me = wd[0]; else begin rd = {63'd0, m_me}; m_me = 0; end end
                7'h04: if (s == 2) begin er = 0;
                           if (!wr) begin rd = {32'd0, m_attn}; attn_clr = 1; end end
                default: ;
            endcase
        end else if (w <= NCH) begin
            case (o)
                7'h00: if (s == 1) begin er = 0;
                           if (wr) m_ctrl[c] = {wd[15:1], wd[0] ? 1'b0 : m_ctrl[c][0]};
                           else begin rd = {48'd0, m_ctrl[c]}; m_ctrl[c][8] = 1'b1; end end
                7'h02: if (s == 0) begin er = 0; if (wr) stb = NCH'(1) << c; end
                7'h04: if (s == 2) begin er = 0;
                           if (wr) m_err[c] = m_err[c] & ~wd[31:0]; else rd = {32'd0, m_err[c]}; end
                7'h08: if (s >= 2) begin er = 0;
                           if (wr) m_chain[c] = (s == 3) ? wd : {m_chain[c][63:32], wd[31:0]};
                           else rd = (s == 3) ? m_chain[c] : {32'd0, m_chain[c][31:0]}; end
                7'h0C: if (s == 2) begin er = 0;
                           if (wr) m_chain[c] = {wd[31:0], m_chain[c][31:0]};
                           else rd = {32'd0, m_chain[c][63:32]}; end
                7'h10: if (s >= 2) begin er = 0;
                           if (wr) m_cmpl[c] = (s == 3) ? wd : {m_cmpl[c][63:32], wd[31:0]};
                           else rd = (s == 3) ? m_cmpl[c] : {32'd0, m_cmpl[c][31:0]}; end
                7'h14: if (s == 2) begin er = 0;
                           if (wr) m_cmpl[c] = {wd[31:0], m_cmpl[c][31:0]};
                           else rd = {32'd0, m_cmpl[c][63:32]}; end
                7'h18: if (s == 3) begin er = 0; if (!wr) rd = {63'd0, !chan_busy[c]}; end
                default: ;
            endcase
        end
        m_attn = (attn_clr ? 32'd0 : m_attn) | aset;
        if (ev) m_err[ec] = m_err[ec] | eb;
    endtask

    task automatic access(input logic wr, input logic [15:0] a, input logic [1:0] s,
                          input logic [63:0] wd, input logic [31:0] aset = 0,
                          input logic ev = 0, input logic [1:0] ec = 0, input logic [31:0] eb = 0);
        logic [63:0] erd; logic eer; logic [NCH-1:0] estb;
        string t = tag_of(a);
        model(wr, a, s, wd, aset, ev, ec, eb, erd, eer, estb);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_size = s; req_wdata = wd;
        attn_set = aset; err_set_valid = ev; err_set_chan = ec; err_set_bits = eb;
        @(negedge clk);
        req_valid = 0; attn_set = 0; err_set_valid = 0;
        check64({t, " rsp_valid (R10)"}, 64'(rsp_valid), 64'd1);
        check64({t, " rdata"}, rsp_rdata, erd);
        check64({t, " err"}, 64'(rsp_err), 64'(eer));
        check64({t, " strobe (R9)"}, 64'(cmd_strobe), 64'(estb));
        if (estb != 0) check64({t, " cmd_data R9"}, 64'(cmd_data), 64'(wd[7:0]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [6:0] offs [12] = '{7'h00, 7'h01, 7'h02, 7'h04, 7'h08, 7'h0C,
                                  7'h10, 7'h14, 7'h18, 7'h03, 7'h7F, 7'h20};
        void'($urandom(32'd20240917));
        for (int c = 0; c < NCH; c++) begin
            m_ctrl[c] = 16'h0001; m_chain[c] = 0; m_cmpl[c] = 0; m_err[c] = 0;
        end
        m_me = 0; m_attn = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // reset state R10
        check64("R10 reset req_ready", 64'(req_ready), 64'd1);
        check64("R10 reset rsp_valid", 64'(rsp_valid), 64'd0);
        check64("R9 reset strobe", 64'(cmd_strobe), 64'd0);

        // R3 identity registers and ignored writes
        access(0, 16'h0000, 0, 0);
        access(0, 16'h0001, 0, 0);
        access(1, 16'h0000, 0, 64'hFF);
        access(0, 16'h0000, 0, 0);
        // R1 channel window out of range, R2 wrong size / unknown offset
        access(0, 16'h0280, 1, 0);
        access(1, 16'h0080, 2, 64'hFFFF);
        access(0, 16'h0083, 0, 0);
        // R6 control reset, in-use set on read, int-disable clear on write 1
        access(0, 16'h0100, 1, 0);
        access(0, 16'h0100, 1, 0);
        access(1, 16'h0100, 1, 64'h00F0);
        access(0, 16'h0100, 1, 0);
        access(1, 16'h0100, 1, 64'h0001);
        access(0, 16'h0100, 1, 0);
        // R7 split halves
        access(1, 16'h0088, 3, 64'h1122334455667788);
        access(1, 16'h008C, 2, 64'hAABBCCDD);
        access(0, 16'h0088, 3, 0);
        access(1, 16'h0090, 2, 64'h01020304);
        access(0, 16'h0094, 2, 0);
        // R5 master enable
        access(1, 16'h0002, 0, 64'h3);
        access(0, 16'h0002, 0, 0);
        access(0, 16'h0002, 0, 0);
        // R4 collision: set 0xA5, then read while set 0x0F
        access(0, 16'h0000, 0, 0, 32'h000000A5);
        access(0, 16'h0004, 2, 0, 32'h0000000F);
        access(0, 16'h0004, 2, 0);
        // R8 collision on channel 1
        access(0, 16'h0000, 0, 0, 0, 1, 2'd1, 32'h000000FF);
        access(1, 16'h0104, 2, 64'h0000010F, 0, 1, 2'd1, 32'h00000100);
        access(0, 16'h0104, 2, 0);
        // R9 command strobe and read-as-zero
        access(1, 16'h0182, 0, 64'h5A);
        access(0, 16'h0182, 0, 0);
        // R11 status
        access(0, 16'h0098, 3, 0);
        access(0, 16'h0118, 3, 0);
        access(1, 16'h0118, 3, 64'hFFFF);

        // R10 response held while rsp_ready low
        @(negedge clk);
        rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 16'h0000; req_size = 0;
        @(negedge clk); req_valid = 0;
        @(negedge clk);
        check64("R10 held rsp_valid", 64'(rsp_valid), 64'd1);
        check64("R10 held req_ready", 64'(req_ready), 64'd0);
        check64("R10 held rdata", rsp_rdata, 64'(NCH));
        rsp_ready = 1;
        @(negedge clk);
        check64("R10 released", 64'(rsp_valid), 64'd0);

        // constrained random traffic
        for (int i = 0; i < 600; i++) begin
            logic [15:0] a;
            logic [31:0] as;
            logic ev;
            a = {7'($urandom_range(0, NCH + 1)), 2'b00, offs[$urandom_range(0, 11)]};
            a = {a[15:7] >> 2, a[6:0]};
            as = ($urandom_range(0, 3) == 0) ? $urandom : 32'd0;
            ev = ($urandom_range(0, 3) == 0);
            if (i == 300) chan_busy = 4'b1010;
            access(1'($urandom_range(0, 1)), a, 2'($urandom_range(0, 3)),
                   {$urandom, $urandom}, as, ev, 2'($urandom_range(0, 3)), $urandom);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule